// File: doc/BRIEF.md
# Clause 22 MDIO Management Master

This block lets software manage Ethernet PHYs over a two-wire management bus. A single 32-bit command word, reached through a small register port, holds the PHY address, register address, transfer direction and write data. When it is written, the block generates the management clock and shifts out a standard Clause 22 frame. For reads it releases the data line at the turnaround and shifts in the PHY's 16-bit reply.

Software follows progress by reading the same word. It contains a busy flag, a read-valid flag and, after a read, the captured data. Every completed transfer also sets a sticky completion cause bit, and a mask register can route that bit onto an interrupt line. This lets a driver sleep instead of polling. Software clears the cause bit by writing zero to it.

The management clock runs only while a frame is in flight. Its half period is `CLK_HALF` system clocks, so a frame lasts 128 × `CLK_HALF` cycles.

Top module: `mdio_mgmt_master`

## Requirements
- R1: Command word at offset 0x00: data in bits 15:0, PHY address in bits 20:16, register address in bits 25:21, and bit 26 is the direction (1 = read, 0 = write). A read of the word returns the stored fields in the same positions.
- R2: Bit 28 of the command word reads 1 from the clock edge that accepts a command until its frame ends. That is exactly 128 × CLK_HALF cycles.
- R3: The frame has 64 bits, MSB first: 32 ones, then start bits 01, then opcode 10 for a read or 01 for a write, then the 5-bit PHY address, then the 5-bit register address, then turnaround 10 on a write, then 16 data bits.
- R4: MDC stays low while idle. The data output changes only after a falling MDC edge, and the input is sampled on the rising edge.
- R5: On a read, the output enable is low for frame bits 46 to 63. The 16 bits sampled there, MSB first, appear in bits 15:0, and bit 27 reads 1 once the frame ends.
- R6: A command write while bit 28 is 1 is ignored. Accepting a new command clears bit 27.
- R7: Bit 4 of the cause register at offset 0x7C is set when any frame ends. Writing 0 to that bit clears it, and writing 1 leaves it unchanged. A completion in the same cycle as a clear wins.
- R8: Bit 4 of the mask register at offset 0x80 is stored and read back. The irq output equals cause bit 4 AND mask bit 4.
- R9: After reset all three registers read 0, and mdc, mdio_oe and irq are 0.
- R10: No frame keeps the block busy for longer than 128 × CLK_HALF cycles, which is far below 1 ms at any practical divider.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |
| irq | output | 1 | Completion interrupt |

## Verification
The assertions check on every cycle the following:
- MDC is low while idle.
- The data output holds between falling edges.
- A frame stays within its cycle bound.
- Busy writes leave the command fields untouched.
- Acceptance clears read-valid.
- Completion sets the cause bit.
- The interrupt never rises while masked.

Only the bench's scenarios can show that the whole serial bit pattern is correct, that a PHY reply ends up in the data field, and that the exact busy duration is right. They also show the write-zero and write-one behaviour of the cause bit as seen through the register port.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int TA_FIRST   = 46;
  localparam int DATA_FIRST = 48;
  localparam int DONE_BIT   = 4;

  typedef struct packed {
    logic        rd;
    logic [4:0]  regad;
    logic [4:0]  phy;
    logic [15:0] data;
  } mdio_cmd_t;

  function automatic logic [FRAME_BITS-1:0] build_frame(mdio_cmd_t c);
    logic [17:0] tail;
    tail = c.rd ? 18'h3FFFF : {2'b10, c.data};
    return {32'hFFFF_FFFF, 2'b01, (c.rd ? 2'b10 : 2'b01), c.phy, c.regad, tail};
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int CLK_HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = $clog2(CLK_HALF + 1);
  localparam logic [CW-1:0] LAST = CW'(CLK_HALF - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;
  logic          wrap;

  always_comb begin
    wrap      = run && (cnt_q == LAST);
    rise_tick = wrap && !mdc_q;
    fall_tick = wrap && mdc_q;
    cnt_d     = cnt_q;
    mdc_d     = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (wrap) begin
      cnt_d = '0;
      mdc_d = !mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc = mdc_q;

  AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !mdc); // R4
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
#(
  parameter int CLK_HALF = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  mdio_cmd_t   cmd,
  input  logic        rise_tick,
  input  logic        fall_tick,
  input  logic        mdio_i,
  output logic        busy,
  output logic        done,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic [15:0] rd_data
);
  localparam int FRAME_CYC = 2 * CLK_HALF * FRAME_BITS;
  localparam int IW = $clog2(FRAME_BITS);
  localparam int TW = $clog2(FRAME_CYC + 1);
  localparam logic [IW-1:0] LAST_IDX = IW'(FRAME_BITS - 1);

  logic                  busy_q, busy_d;
  logic                  rd_q, rd_d;
  logic [IW-1:0]         idx_q, idx_d;
  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic [15:0]           cap_q, cap_d;

  always_comb begin
    busy_d = busy_q;
    rd_d   = rd_q;
    idx_d  = idx_q;
    sh_d   = sh_q;
    cap_d  = cap_q;
    done   = busy_q && fall_tick && (idx_q == LAST_IDX);
    if (start && !busy_q) begin
      busy_d = 1'b1;
      rd_d   = cmd.rd;
      idx_d  = '0;
      sh_d   = build_frame(cmd);
      cap_d  = '0;
    end else if (busy_q) begin
      if (rise_tick && rd_q && (idx_q >= IW'(DATA_FIRST)))
        cap_d = {cap_q[14:0], mdio_i};
      if (fall_tick) begin
        if (idx_q == LAST_IDX) begin
          busy_d = 1'b0;
        end else begin
          idx_d = idx_q + 1'b1;
          sh_d  = {sh_q[FRAME_BITS-2:0], 1'b1};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      idx_q  <= '0;
      sh_q   <= '0;
      cap_q  <= '0;
    end else begin
      busy_q <= busy_d;
      rd_q   <= rd_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      cap_q  <= cap_d;
    end
  end

  assign busy    = busy_q;
  assign mdio_o  = sh_q[FRAME_BITS-1];
  assign mdio_oe = busy_q && !(rd_q && (idx_q >= IW'(TA_FIRST)));
  assign rd_data = cap_q;

  logic [TW-1:0] tmr_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tmr_q <= '0;
    else if (busy_q) tmr_q <= tmr_q + 1'b1;
    else             tmr_q <= '0;
  end

  AST_FRAME_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (tmr_q < TW'(FRAME_CYC))); // R10
  AST_MDIO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q) && !$past(fall_tick)) |-> $stable(mdio_o)); // R4
endmodule

// File: rtl/mdio_irq_unit.sv
module mdio_irq_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic done,
  input  logic wr_cause,
  input  logic wr_mask,
  input  logic wbit,
  output logic cause,
  output logic mask,
  output logic irq
);
  logic cause_q, cause_d, mask_q, mask_d;

  always_comb begin
    cause_d = cause_q;
    if (done)                  cause_d = 1'b1;
    else if (wr_cause && !wbit) cause_d = 1'b0;
    mask_d = wr_mask ? wbit : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= 1'b0;
      mask_q  <= 1'b0;
    end else begin
      cause_q <= cause_d;
      mask_q  <= mask_d;
    end
  end

  assign cause = cause_q;
  assign mask  = mask_q;
  assign irq   = cause_q && mask_q;

  AST_CAUSE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> cause); // R7
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_pkg::*;
#(
  parameter int          CLK_HALF  = 4,
  parameter logic [7:0]  CMD_OFF   = 8'h00,
  parameter logic [7:0]  CAUSE_OFF = 8'h7C,
  parameter logic [7:0]  MASK_OFF  = 8'h80
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i,
  output logic        irq
);
  mdio_cmd_t   cmd_q, cmd_d, new_cmd;
  logic        rvalid_q, rvalid_d;
  logic        busy, done, accept, rise_tick, fall_tick;
  logic        cause, mask;
  logic [15:0] rd_data;
  logic        unused_wbits;

  assign unused_wbits = ^{reg_wdata[31:27], reg_wdata[3:0]};

  always_comb begin
    new_cmd = mdio_cmd_t'(reg_wdata[26:0]);
    accept  = reg_wr && (reg_addr == CMD_OFF) && !busy;
    cmd_d    = cmd_q;
    rvalid_d = rvalid_q;
    if (accept) begin
      cmd_d    = new_cmd;
      rvalid_d = 1'b0;
    end else if (done && cmd_q.rd) begin
      cmd_d.data = rd_data;
      rvalid_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q    <= '0;
      rvalid_q <= 1'b0;
    end else begin
      cmd_q    <= cmd_d;
      rvalid_q <= rvalid_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == CMD_OFF)        reg_rdata = {3'b000, busy, rvalid_q, cmd_q};
    else if (reg_addr == CAUSE_OFF) reg_rdata[DONE_BIT] = cause;
    else if (reg_addr == MASK_OFF)  reg_rdata[DONE_BIT] = mask;
  end

  mdio_clkgen #(.CLK_HALF(CLK_HALF)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(busy),
    .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick));

  mdio_frame_seq #(.CLK_HALF(CLK_HALF)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept), .cmd(new_cmd),
    .rise_tick(rise_tick), .fall_tick(fall_tick), .mdio_i(mdio_i),
    .busy(busy), .done(done), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .rd_data(rd_data));

  mdio_irq_unit u_irq (
    .clk(clk), .rst_n(rst_n), .done(done),
    .wr_cause(reg_wr && (reg_addr == CAUSE_OFF)),
    .wr_mask(reg_wr && (reg_addr == MASK_OFF)),
    .wbit(reg_wdata[DONE_BIT]),
    .cause(cause), .mask(mask), .irq(irq));

  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && reg_wr && (reg_addr == CMD_OFF)) |=> $stable(cmd_q)); // R6
  AST_ACCEPT_CLEARS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!rvalid_q && busy)); // R6
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !mask |-> !irq); // R8
endmodule

// File: tb/mdio_mgmt_master_test.sv
module mdio_mgmt_master_test;
  localparam int HALF = 4;
  localparam int FRAME_CYC = 128 * HALF;

  logic        clk, rst_n, reg_wr, mdio_i;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mdc, mdio_o, mdio_oe, irq;

  int errors = 0;
  int checks = 0;

  logic [63:0] cap, oe_log;
  int          idx;
  logic [15:0] resp;

  mdio_mgmt_master #(.CLK_HALF(HALF)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i), .irq(irq));

  initial clk = 1'b0;
  always #5 clk = !clk;

  // PHY responder: record master bits at rising MDC, drive reply after falling MDC
  always @(posedge mdc) begin
    if (idx < 64) begin
      cap[63-idx]    = mdio_o;
      oe_log[63-idx] = mdio_oe;
      idx++;
    end
  end
  always @(negedge mdc) begin
    #1;
    if (idx >= 48 && idx < 64) mdio_i = resp[63-idx];
    else                       mdio_i = 1'b1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_frame(bit rd, logic [4:0] phy, logic [4:0] rg,
                                            logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, phy, rg, 2'b10, d};
  endfunction

  function automatic logic [31:0] cmd_word(bit rd, logic [4:0] phy, logic [4:0] rg,
                                           logic [15:0] d);
    return {5'b0, rd, rg, phy, d};
  endfunction

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle(output int n);
    logic [31:0] v;
    n = 0;
    forever begin
      bus_read(8'h00, v);
      if (!v[28] || n > 4 * FRAME_CYC) break;
      n++;
      @(negedge clk);
    end
  endtask

  task automatic run_op(input bit rd, input logic [4:0] phy, input logic [4:0] rg,
                        input logic [15:0] d, input bit check_len);
    int n;
    logic [31:0] v;
    logic [63:0] ef;
    idx = 0;
    cap = '0; oe_log = '0;
    bus_write(8'h00, cmd_word(rd, phy, rg, d));
    bus_read(8'h00, v);
    chk(v[28] == 1'b1 && v[27] == 1'b0, "R6", "busy set, valid cleared on accept",
        {32'b0, v}, {32'b0, 4'b0001, v[27:0] & 28'h7FFFFFF});
    @(negedge clk);
    wait_idle(n);
    n = n + 1;
    if (check_len) chk(n == FRAME_CYC, "R2", "busy duration", 64'(n), 64'(FRAME_CYC));
    chk(n <= FRAME_CYC, "R10", "frame bound", 64'(n), 64'(FRAME_CYC));
    ef = exp_frame(rd, phy, rg, rd ? resp : d);
    if (rd) begin
      chk(cap[63:18] == ef[63:18], "R3", "read frame header", {18'b0, cap[63:18]}, {18'b0, ef[63:18]});
      chk(oe_log == {46'h3FFF_FFFF_FFFF, 18'h0}, "R5", "read release window", oe_log,
          {46'h3FFF_FFFF_FFFF, 18'h0});
      bus_read(8'h00, v);
      chk(v[15:0] == resp && v[27] && !v[28], "R5", "read data and valid",
          {32'b0, v}, {32'b0, 4'b0000, 1'b1, 1'b1, rg, phy, resp});
      chk(v[26:16] == {1'b1, rg, phy}, "R1", "read fields", 64'(v[26:16]), 64'({1'b1, rg, phy}));
    end else begin
      chk(cap == ef, "R3", "write frame", cap, ef);
      chk(&oe_log, "R4", "write drives all bits", oe_log, {64{1'b1}});
      bus_read(8'h00, v);
      chk(v[26:0] == cmd_word(0, phy, rg, d)[26:0] && !v[27], "R1", "write fields",
          {32'b0, v}, {32'b0, cmd_word(0, phy, rg, d)});
    end
    bus_read(8'h7C, v);
    chk(v == 32'h10, "R7", "cause set on completion", {32'b0, v}, 64'h10);
    bus_write(8'h7C, 32'h0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n;
    void'($urandom(32'd11));
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; mdio_i = 1'b1;
    idx = 64; resp = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    bus_read(8'h00, v); chk(v == 0, "R9", "cmd reset", {32'b0, v}, 0);
    bus_read(8'h7C, v); chk(v == 0, "R9", "cause reset", {32'b0, v}, 0);
    bus_read(8'h80, v); chk(v == 0, "R9", "mask reset", {32'b0, v}, 0);
    chk(!mdc && !mdio_oe && !irq, "R9", "pins reset", {61'b0, mdc, mdio_oe, irq}, 0);

    // directed corner values
    resp = 16'hFFFF; run_op(1, 5'd31, 5'd31, 16'h0, 1);
    run_op(0, 5'd0, 5'd0, 16'h0000, 1);
    resp = 16'h0001; run_op(1, 5'd0, 5'd1, 16'h0, 0);
    run_op(0, 5'd31, 5'd31, 16'hFFFF, 0);

    // constrained random mix
    for (int i = 0; i < 16; i++) begin
      bit rd;
      rd   = 1'($urandom);
      resp = 16'($urandom);
      run_op(rd, 5'($urandom), 5'($urandom), 16'($urandom), 0);
    end

    // R6 command while busy is ignored
    idx = 0; cap = '0;
    bus_write(8'h00, cmd_word(0, 5'd3, 5'd9, 16'hA5C3));
    repeat (40) @(negedge clk);
    bus_write(8'h00, cmd_word(1, 5'd17, 5'd22, 16'h1234));
    wait_idle(n);
    chk(cap == exp_frame(0, 5'd3, 5'd9, 16'hA5C3), "R6", "busy write ignored on wire",
        cap, exp_frame(0, 5'd3, 5'd9, 16'hA5C3));
    bus_read(8'h00, v);
    chk(v[26:0] == cmd_word(0, 5'd3, 5'd9, 16'hA5C3)[26:0], "R6", "busy write ignored in reg",
        {32'b0, v}, {32'b0, cmd_word(0, 5'd3, 5'd9, 16'hA5C3)});

    // R7 cause write-one keeps, write-zero clears
    bus_read(8'h7C, v); chk(v == 32'h10, "R7", "cause pending", {32'b0, v}, 64'h10);
    bus_write(8'h7C, 32'h10);
    bus_read(8'h7C, v); chk(v == 32'h10, "R7", "write one keeps cause", {32'b0, v}, 64'h10);
    // R8 masking
    #1 chk(irq == 1'b0, "R8", "irq masked", 64'(irq), 0);
    bus_write(8'h80, 32'h10);
    bus_read(8'h80, v); chk(v == 32'h10, "R8", "mask readback", {32'b0, v}, 64'h10);
    #1 chk(irq == 1'b1, "R8", "irq unmasked", 64'(irq), 1);
    bus_write(8'h7C, 32'hFFFF_FFEF);
    bus_read(8'h7C, v); chk(v == 0, "R7", "write zero clears cause", {32'b0, v}, 0);
    #1 chk(irq == 1'b0, "R8", "irq drops after clear", 64'(irq), 0);
    chk(!mdc, "R4", "mdc low when idle", 64'(mdc), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule